// File: doc/BRIEF.md
# Flux vector sector identifier

This block places the stator flux vector of a field-oriented or direct-torque motor drive into one of six 60° sectors of the D/Q plane. It does this without computing an angle. Three comparisons of the quadrature component against zero and against plus and minus √3 times the direct component run side by side. The three resulting flags select the sector directly. The √3 scaling is a fixed-point product that keeps every bit before it is compared.

A sample is offered with a one-cycle valid strobe. In the next clock cycle the sector number (1 for 0°–60°, increasing counter-clockwise up to 6 for 300°–360°) appears on a register, together with a one-cycle valid pulse. Between strobes the sector output holds its last value.

Top module: `flux_sector_id`

## Requirements
- R1: After reset, `sector_o` is 0 and `valid_o` is 0, and both stay so until the first strobe.
- R2: `valid_o` is high in exactly the cycles that follow a cycle with `valid_i` high.
- R3: `sector_o` encodes the sector as an unsigned 3-bit number: 1 = [0°,60°), 2 = [60°,120°), 3 = [120°,180°), 4 = [180°,240°), 5 = [240°,300°), 6 = [300°,360°). The sector is taken from the flag triple (Q>0, Q>√3·D, Q>−√3·D) as follows: 101→1, 111→2, 110→3, 010→4, 000→5, 001→6.
- R4: While `valid_i` is low, the flux inputs are ignored and `sector_o` keeps its value.
- R5: The √3 comparisons are exact against the constant SQRT3_K/2^SQRT3_FRAC (default 454047/2^18). With D = 2^18 and Q = 454048 the result is 2, and with D = −2^18 and Q = 454048 the result is also 2.
- R6: Every comparison is a strict "greater than". So the positive D axis (Q=0, D>0) gives 6, the negative D axis gives 4, the positive Q axis gives 2 and the negative Q axis gives 5. The origin gives 5. An exact 60° line point (D=2^18, Q=454047) gives 1, the exact 120° point gives 3, and the exact 300° point gives 5.
- R7: Full-scale inputs of either sign give the correct sector with no overflow. Examples: (−2^23, −2^23) gives 4, (2^23−1, −2^23) gives 6, and (2^23−1, 2^23−1) gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample strobe, one cycle per sample |
| flux_d_i | input | FLUX_W (24) | Direct flux component, signed two's complement |
| flux_q_i | input | FLUX_W (24) | Quadrature flux component, signed two's complement |
| sector_o | output | 3 | Sector number 1..6, 0 before the first sample |
| valid_o | output | 1 | One-cycle pulse marking a new sector value |

## Verification
Both the sector and its valid pulse are due exactly one clock edge after the edge that captures the strobe. The bench drives inputs on the falling edge and samples one falling edge later, so exactly one rising edge lies in between. The hold and pulse-width checks sample again on later falling edges with the strobe low, and expect the sector to be unchanged and the valid flag to be low. Back-to-back strobes are checked one falling edge apart, so that each result is matched to its own sample.

// File: rtl/flux_sector_pkg.sv
package flux_sector_pkg;

    // Result of the three parallel comparisons
    typedef struct packed {
        logic q_pos;      // Q > 0
        logic q_gt_rise;  // Q > +sqrt3 * D
        logic q_gt_fall;  // Q > -sqrt3 * D
    } cmp_flags_t;

    localparam int SECTOR_W = 3;

    typedef struct packed {
        logic [SECTOR_W-1:0] sector;
        logic                vld;
    } sector_state_t;

endpackage

// File: rtl/sqrt3_scale.sv
module sqrt3_scale #(
    parameter int FLUX_W  = 24,
    parameter int K_W     = 19,
    parameter int PROD_W  = 44,
    parameter int SQRT3_K = 454047
) (
    input  logic signed [FLUX_W-1:0] flux_d,
    output logic signed [PROD_W-1:0] prod_pos,
    output logic signed [PROD_W-1:0] prod_neg
);

    localparam logic signed [PROD_W-1:0] K_EXT = PROD_W'(SQRT3_K);

    logic signed [PROD_W-1:0] d_ext;

    always_comb begin
        d_ext    = {{(PROD_W-FLUX_W){flux_d[FLUX_W-1]}}, flux_d};
        prod_pos = d_ext * K_EXT;
        prod_neg = -prod_pos;
    end

endmodule

// File: rtl/sector_cmp.sv
module sector_cmp
    import flux_sector_pkg::*;
#(
    parameter int FLUX_W = 24,
    parameter int PROD_W = 44,
    parameter int FRAC   = 18
) (
    input  logic signed [FLUX_W-1:0] flux_q,
    input  logic signed [PROD_W-1:0] prod_pos,
    input  logic signed [PROD_W-1:0] prod_neg,
    output cmp_flags_t               flags
);

    logic signed [PROD_W-1:0] q_scaled;

    always_comb begin
        q_scaled        = {{(PROD_W-FLUX_W){flux_q[FLUX_W-1]}}, flux_q} <<< FRAC;
        flags.q_pos     = (flux_q > 0);
        flags.q_gt_rise = (q_scaled > prod_pos);
        flags.q_gt_fall = (q_scaled > prod_neg);
    end

endmodule

// File: rtl/sector_decode.sv
module sector_decode
    import flux_sector_pkg::*;
(
    input  cmp_flags_t          flags,
    input  logic [SECTOR_W-1:0] prev_sector,
    output logic [SECTOR_W-1:0] sector
);

    always_comb begin
        unique case (flags)
            3'b101:  sector = 3'd1;
            3'b111:  sector = 3'd2;
            3'b110:  sector = 3'd3;
            3'b010:  sector = 3'd4;
            3'b000:  sector = 3'd5;
            3'b001:  sector = 3'd6;
            default: sector = prev_sector;  // contradictory triple: keep last
        endcase
    end

endmodule

// File: rtl/flux_sector_id.sv
module flux_sector_id
    import flux_sector_pkg::*;
#(
    parameter int FLUX_W     = 24,
    parameter int SQRT3_FRAC = 18,
    parameter int SQRT3_K    = 454047
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic signed [FLUX_W-1:0] flux_d_i,
    input  logic signed [FLUX_W-1:0] flux_q_i,
    output logic [SECTOR_W-1:0]      sector_o,
    output logic                     valid_o
);

    localparam int K_W    = $clog2(SQRT3_K + 1);
    localparam int HEAD_W = (K_W > SQRT3_FRAC) ? K_W : SQRT3_FRAC;
    localparam int PROD_W = FLUX_W + HEAD_W + 2;

    logic signed [PROD_W-1:0] prod_pos;
    logic signed [PROD_W-1:0] prod_neg;
    cmp_flags_t               flags;
    logic [SECTOR_W-1:0]      sector_new;
    sector_state_t            st_d, st_q;

    sqrt3_scale #(
        .FLUX_W  (FLUX_W),
        .K_W     (K_W),
        .PROD_W  (PROD_W),
        .SQRT3_K (SQRT3_K)
    ) u_scale (
        .flux_d   (flux_d_i),
        .prod_pos (prod_pos),
        .prod_neg (prod_neg)
    );

    sector_cmp #(
        .FLUX_W (FLUX_W),
        .PROD_W (PROD_W),
        .FRAC   (SQRT3_FRAC)
    ) u_cmp (
        .flux_q   (flux_q_i),
        .prod_pos (prod_pos),
        .prod_neg (prod_neg),
        .flags    (flags)
    );

    sector_decode u_dec (
        .flags       (flags),
        .prev_sector (st_q.sector),
        .sector      (sector_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.sector = sector_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sector_o = st_q.sector;
    assign valid_o  = st_q.vld;

endmodule

// File: rtl/flux_sector_id_chk.sv
module flux_sector_id_chk #(
    parameter int FLUX_W = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     valid_i,
    input logic signed [FLUX_W-1:0] flux_d_i,
    input logic signed [FLUX_W-1:0] flux_q_i,
    input logic [2:0]               sector_o,
    input logic                     valid_o
);

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R2
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    // R4
    sector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(sector_o));

    // R3
    sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sector_o >= 3'd1 && sector_o <= 3'd6));

    // R1
    sector_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_o != 3'd0) |=> (sector_o != 3'd0));

    // R6
    origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && flux_d_i == 0 && flux_q_i == 0) |=> (sector_o == 3'd5));

endmodule

bind flux_sector_id flux_sector_id_chk #(.FLUX_W(FLUX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .flux_d_i (flux_d_i),
    .flux_q_i (flux_q_i),
    .sector_o (sector_o),
    .valid_o  (valid_o)
);

// File: tb/flux_sector_id_tb.sv
module flux_sector_id_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 25;

    // D, Q, expected sector, requirement tag index (3=R3,5=R5,6=R6,7=R7)
    localparam int VD [NV] = '{
        1000, 1000, 100, -100, -1000, -1000, -1000, -1000, -100, 100, 1000, 1000,
        262144, -262144,
        5000, -5000, 0, 0, 0, 262144, -262144, 262144,
        -8388608, 8388607, 8388607};
    localparam int VQ [NV] = '{
        100, 1500, 1000, 1000, 1500, 100, -100, -1500, -1000, -1000, -1500, -100,
        454048, 454048,
        0, 0, 5000, -5000, 0, 454047, 454047, -454047,
        -8388608, -8388608, 8388607};
    localparam int VE [NV] = '{
        1, 1, 2, 2, 3, 3, 4, 4, 5, 5, 6, 6,
        2, 2,
        6, 4, 2, 5, 5, 1, 3, 5,
        4, 6, 1};
    localparam int VR [NV] = '{
        3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3,
        5, 5,
        6, 6, 6, 6, 6, 6, 6, 6,
        7, 7, 7};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               valid_i = 1'b0;
    logic signed [23:0] flux_d_i = '0;
    logic signed [23:0] flux_q_i = '0;
    logic [2:0]         sector_o;
    logic               valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    flux_sector_id u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .flux_d_i (flux_d_i),
        .flux_q_i (flux_q_i),
        .sector_o (sector_o),
        .valid_o  (valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one sample, check the result one rising edge later
    task automatic sample(input int d, input int q, input int exp, input string req);
        @(negedge clk);
        flux_d_i = 24'(d);
        flux_q_i = 24'(q);
        valid_i  = 1'b1;
        @(negedge clk);
        valid_i  = 1'b0;
        chk({req, " sector"}, int'(sector_o), exp);
        chk("R2 valid pulse", int'(valid_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sector in reset", int'(sector_o), 0);
        chk("R1 valid in reset", int'(valid_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 sector after reset", int'(sector_o), 0);
        chk("R1 valid after reset", int'(valid_o), 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            sample(VD[i], VQ[i], VE[i], $sformatf("R%0d vec%0d", VR[i], i));
        end

        // R2: pulse is one cycle wide
        @(negedge clk);
        chk("R2 valid low after pulse", int'(valid_o), 0);

        // R4: inputs ignored while strobe low
        sample(1000, 100, 1, "R4 setup");
        flux_d_i = -24'sd1000;
        flux_q_i = -24'sd1500;
        repeat (3) @(negedge clk);
        chk("R4 sector held", int'(sector_o), 1);
        chk("R4 no valid", int'(valid_o), 0);

        // R2: back-to-back strobes
        @(negedge clk);
        flux_d_i = -24'sd1000;
        flux_q_i = 24'sd1500;
        valid_i  = 1'b1;
        @(negedge clk);
        flux_d_i = 24'sd100;
        flux_q_i = -24'sd1000;
        chk("R2 b2b first sector", int'(sector_o), 3);
        chk("R2 b2b first valid", int'(valid_o), 1);
        @(negedge clk);
        valid_i = 1'b0;
        chk("R2 b2b second sector", int'(sector_o), 5);
        chk("R2 b2b second valid", int'(valid_o), 1);
        @(negedge clk);
        chk("R2 b2b valid drops", int'(valid_o), 0);
        chk("R4 b2b sector held", int'(sector_o), 5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule